// File: doc/BRIEF.md
# ISA Command and Refresh Sequencer

This block runs ISA bus cycles for a host-side controller. The cycles are issued for the CPU, for a DMA channel or for memory refresh. A request starts with one clock of address setup, during which ALE is high. The command phase follows, and its nominal width depends on the cycle type. The target can stretch the command with IOCHRDY or cut it short with ZWS#. When the command ends, the block gives a one-clock done pulse.

Refresh is pseudo-hidden. The block drives REF# low and asks for the host bus. Once the bus is granted, it keeps the bus for exactly two clocks so the refresh address can be latched outside the block. It then gives the host bus back and runs the memory-read part of the refresh on the ISA side. A refresh requested during a cycle waits until that cycle has finished.

When an add-on card owns the bus (MASTER# low), the block stops driving the command strobes so they can act as inputs. In that state a falling REF# from the card starts a refresh.

Top module: `isa_cmd_seq`

## Requirements
- R1: While reset is held, and right after it is released, all command strobes, BHE#, REF# and SMEMx# are high. ALE, AEN, host_req_o and done_o are low.
- R2: An accepted request gives ALE high for one clock, then the command phase. The command lasts 4 clocks for a memory cycle with mcs16_ni low, and 6 clocks otherwise. done_o is high for the one clock after the command.
- R3: req_kind_i encoding: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write. A memory read drives MEMR# low, a memory write drives MEMW# low, an I/O read drives IOR# low and an I/O write drives IOW# low. SMEMR# and SMEMW# follow MEMR# and MEMW# only when address bits 23:20 are all zero.
- R4: When req_bhe_i is set, BHE# is low through both the address clock and the command clock. Otherwise BHE# stays high.
- R5: If iochrdy_i is low at or after the nominal last command clock, the command is extended until iochrdy_i is sampled high. zws_ni sampled low during any command clock makes that clock the last one.
- R6: mcs16_ni has no effect on the width of I/O cycles or refresh cycles.
- R7: A refresh drives REF# low with ref_oe_o high and raises host_req_o. After host_gnt_i, raddr_oe_o is high for exactly two clocks and host_req_o then falls. MEMR# and SMEMR# are then low for 6 clocks, and done_o follows.
- R8: A refresh requested during a cycle starts in the clock right after that cycle's done pulse. Any number of refresh requests during one cycle give exactly one refresh.
- R9: While master_ni is low, cmd_oe_o and ref_oe_o are low and req_valid_i starts no cycle. A falling ref_ni then starts a refresh (host hold and ISA part) without driving REF#.
- R10: aen_o is high only during the address and command clocks of a cycle issued with req_dma_i set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ISA clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Cycle request, accepted when idle |
| req_kind_i | input | 2 | Cycle kind (see R3) |
| req_addr_i | input | 24 | Cycle address |
| req_bhe_i | input | 1 | Byte on data lines 15:8 |
| req_dma_i | input | 1 | Cycle is issued by DMA |
| ref_req_i | input | 1 | Refresh request pulse |
| master_ni | input | 1 | Add-on card owns the bus |
| ref_ni | input | 1 | REF# sampled as input |
| mcs16_ni | input | 1 | 16-bit memory target |
| zws_ni | input | 1 | Zero wait state |
| iochrdy_i | input | 1 | Channel ready |
| host_gnt_i | input | 1 | Host bus grant |
| memr_no | output | 1 | Memory read strobe |
| memw_no | output | 1 | Memory write strobe |
| smemr_no | output | 1 | Below-1MB memory read strobe |
| smemw_no | output | 1 | Below-1MB memory write strobe |
| ior_no | output | 1 | I/O read strobe |
| iow_no | output | 1 | I/O write strobe |
| bhe_no | output | 1 | Byte-high enable |
| ref_no | output | 1 | Refresh strobe |
| ale_o | output | 1 | Address latch enable |
| aen_o | output | 1 | DMA address enable |
| cmd_oe_o | output | 1 | Output enable for MEMR#, MEMW#, IOR#, IOW# and BHE# |
| ref_oe_o | output | 1 | Output enable for REF# |
| host_req_o | output | 1 | Host bus request for refresh |
| raddr_oe_o | output | 1 | Drive refresh address on the host bus |
| done_o | output | 1 | Cycle finished pulse |

## Verification
The assertions rely on a few input rules:
- master_ni changes only while the block is idle.
- host_gnt_i, once given, stays high while host_req_o is high.
- req_valid_i is raised only while the block is idle.

The stimulus follows all three rules. Requests start only from the idle clock after a done pulse. The card takes the bus only after all cycles have completed. The grant is held high from the clock it is first given until the refresh has finished its host-hold phase.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;
  typedef enum logic [1:0] {
    K_MRD  = 2'd0,
    K_MWR  = 2'd1,
    K_IORD = 2'd2,
    K_IOWR = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_HREQ, S_HOLD, S_RECOV
  } seq_st_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      low1m;
    logic      bhe;
    logic      dma;
    logic      rfsh;
  } cyc_info_t;

  localparam cyc_info_t REF_INFO = '{kind: K_MRD, low1m: 1'b1, bhe: 1'b0, dma: 1'b0, rfsh: 1'b1};
endpackage

// File: rtl/isa_ref_trig.sv
module isa_ref_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_req_i,
  input  logic master_ni,
  input  logic ref_ni,
  input  logic take_i,
  output logic pend_o
);
  logic ref_q, pend_q, trig;

  // card-driven refresh: falling REF# while the card owns the bus
  assign trig = ref_req_i | (~master_ni & ref_q & ~ref_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      ref_q  <= ref_ni;
      pend_q <= trig | (pend_q & ~take_i);
    end
  end

  assign pend_o = pend_q;

  a_r8_take_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_q);
  a_r8_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !trig) |=> !pend_q);
endmodule

// File: rtl/isa_cyc_ctl.sv
module isa_cyc_ctl
  import isa_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MB_BIT    = 20,
  parameter int N_WIDE    = 4,
  parameter int N_NARROW  = 6,
  parameter int HOLD_CLKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_bhe_i,
  input  logic              req_dma_i,
  input  logic              ref_pend_i,
  input  logic              master_ni,
  input  logic              mcs16_ni,
  input  logic              zws_ni,
  input  logic              iochrdy_i,
  input  logic              host_gnt_i,
  output seq_st_e           state_o,
  output cyc_info_t         info_o,
  output logic              take_ref_o
);
  localparam int NMAX  = (N_WIDE > N_NARROW) ? N_WIDE : N_NARROW;
  localparam int CNT_W = $clog2(NMAX + 1) + 1;
  localparam int HLD_W = $clog2(HOLD_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  seq_st_e          state_q, state_d;
  cyc_info_t        info_q, info_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, n_q, n_d;
  logic [HLD_W-1:0] hold_q, hold_d;
  logic             cmd_end;

  assign cmd_end = ~zws_ni | ((cnt_q >= n_q) & iochrdy_i);

  always_comb begin
    state_d    = state_q;
    info_d     = info_q;
    cnt_d      = cnt_q;
    n_d        = n_q;
    hold_d     = hold_q;
    take_ref_o = 1'b0;
    unique case (state_q)
      S_IDLE, S_RECOV: begin
        if (ref_pend_i) begin
          take_ref_o = 1'b1;
          info_d     = REF_INFO;
          state_d    = S_HREQ;
        end else if (state_q == S_IDLE && req_valid_i && master_ni) begin
          info_d.kind  = cyc_kind_e'(req_kind_i);
          info_d.low1m = (req_addr_i[ADDR_W-1:MB_BIT] == '0);
          info_d.bhe   = req_bhe_i;
          info_d.dma   = req_dma_i;
          info_d.rfsh  = 1'b0;
          state_d      = S_ADDR;
        end else begin
          state_d = S_IDLE;
        end
      end
      S_ADDR: begin
        n_d     = (!info_q.kind[1] && !mcs16_ni) ? CNT_W'(N_WIDE) : CNT_W'(N_NARROW);
        cnt_d   = CNT_W'(1);
        state_d = S_CMD;
      end
      S_HREQ: begin
        if (host_gnt_i) begin
          hold_d  = '0;
          state_d = S_HOLD;
        end
      end
      S_HOLD: begin
        if (hold_q == HLD_W'(HOLD_CLKS - 1)) begin
          n_d     = CNT_W'(N_NARROW);
          cnt_d   = CNT_W'(1);
          state_d = S_CMD;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
      S_CMD: begin
        if (cmd_end) state_d = S_RECOV;
        else if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      info_q  <= '0;
      cnt_q   <= '0;
      n_q     <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      info_q  <= info_d;
      cnt_q   <= cnt_d;
      n_q     <= n_d;
      hold_q  <= hold_d;
    end
  end

  assign state_o = state_q;
  assign info_o  = info_q;

  a_r7_hold_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMD && $past(state_q) == S_HOLD) |-> $past(state_q, 2) == S_HOLD);
  a_r5_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RECOV && $past(state_q) == S_CMD && $past(zws_ni)) |-> $past(cnt_q) >= $past(n_q));
  a_r5_ready_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMD && cnt_q >= n_q && iochrdy_i) |=> state_q != S_CMD);
endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
  import isa_seq_pkg::*;
(
  input  seq_st_e   state_i,
  input  cyc_info_t info_i,
  output logic      memr_no,
  output logic      memw_no,
  output logic      smemr_no,
  output logic      smemw_no,
  output logic      ior_no,
  output logic      iow_no,
  output logic      bhe_no,
  output logic      ref_no,
  output logic      ale_o,
  output logic      aen_o
);
  logic in_cmd, in_cyc, mrd, mwr;

  assign in_cmd = (state_i == S_CMD);
  assign in_cyc = (state_i == S_ADDR) | in_cmd;
  assign mrd    = in_cmd & (info_i.kind == K_MRD);
  assign mwr    = in_cmd & (info_i.kind == K_MWR) & ~info_i.rfsh;

  assign memr_no  = ~mrd;
  assign memw_no  = ~mwr;
  assign smemr_no = ~(mrd & info_i.low1m);
  assign smemw_no = ~(mwr & info_i.low1m);
  assign ior_no   = ~(in_cmd & (info_i.kind == K_IORD) & ~info_i.rfsh);
  assign iow_no   = ~(in_cmd & (info_i.kind == K_IOWR) & ~info_i.rfsh);
  assign bhe_no   = ~(in_cyc & info_i.bhe & ~info_i.rfsh);
  assign ref_no   = ~(info_i.rfsh & ((state_i == S_HREQ) | (state_i == S_HOLD) | in_cmd));
  assign ale_o    = (state_i == S_ADDR);
  assign aen_o    = in_cyc & info_i.dma & ~info_i.rfsh;
endmodule

// File: rtl/isa_cmd_seq.sv
module isa_cmd_seq
  import isa_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MB_BIT    = 20,
  parameter int N_WIDE    = 4,
  parameter int N_NARROW  = 6,
  parameter int HOLD_CLKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_bhe_i,
  input  logic              req_dma_i,
  input  logic              ref_req_i,
  input  logic              master_ni,
  input  logic              ref_ni,
  input  logic              mcs16_ni,
  input  logic              zws_ni,
  input  logic              iochrdy_i,
  input  logic              host_gnt_i,
  output logic              memr_no,
  output logic              memw_no,
  output logic              smemr_no,
  output logic              smemw_no,
  output logic              ior_no,
  output logic              iow_no,
  output logic              bhe_no,
  output logic              ref_no,
  output logic              ale_o,
  output logic              aen_o,
  output logic              cmd_oe_o,
  output logic              ref_oe_o,
  output logic              host_req_o,
  output logic              raddr_oe_o,
  output logic              done_o
);
  seq_st_e   state;
  cyc_info_t info;
  logic      ref_pend, take_ref;

  isa_ref_trig u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_req_i (ref_req_i),
    .master_ni (master_ni),
    .ref_ni    (ref_ni),
    .take_i    (take_ref),
    .pend_o    (ref_pend)
  );

  isa_cyc_ctl #(
    .ADDR_W    (ADDR_W),
    .MB_BIT    (MB_BIT),
    .N_WIDE    (N_WIDE),
    .N_NARROW  (N_NARROW),
    .HOLD_CLKS (HOLD_CLKS)
  ) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_addr_i  (req_addr_i),
    .req_bhe_i   (req_bhe_i),
    .req_dma_i   (req_dma_i),
    .ref_pend_i  (ref_pend),
    .master_ni   (master_ni),
    .mcs16_ni    (mcs16_ni),
    .zws_ni      (zws_ni),
    .iochrdy_i   (iochrdy_i),
    .host_gnt_i  (host_gnt_i),
    .state_o     (state),
    .info_o      (info),
    .take_ref_o  (take_ref)
  );

  isa_strobe_gen u_stb (
    .state_i  (state),
    .info_i   (info),
    .memr_no  (memr_no),
    .memw_no  (memw_no),
    .smemr_no (smemr_no),
    .smemw_no (smemw_no),
    .ior_no   (ior_no),
    .iow_no   (iow_no),
    .bhe_no   (bhe_no),
    .ref_no   (ref_no),
    .ale_o    (ale_o),
    .aen_o    (aen_o)
  );

  // strobes turn into inputs while a card owns the bus
  assign cmd_oe_o   = master_ni;
  assign ref_oe_o   = master_ni;
  assign host_req_o = (state == S_HREQ) | (state == S_HOLD);
  assign raddr_oe_o = (state == S_HOLD);
  assign done_o     = (state == S_RECOV);

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  a_r3_smemr_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smemr_no |-> !memr_no);
  a_r3_smemw_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smemw_no |-> !memw_no);
  a_r9_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_ni && !$past(master_ni)) |-> !ale_o);
  a_r10_aen_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |-> master_ni);
  a_r7_release_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_req_o) |-> $past(raddr_oe_o) && $past(raddr_oe_o, 2));
endmodule

// File: tb/sim_isa_cmd_seq.sv
module sim_isa_cmd_seq;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 0, req_bhe = 0, req_dma = 0, ref_req = 0;
  logic master_n = 1, ref_n = 1, mcs16_n = 1, zws_n = 1, rdy = 1, gnt = 0;
  logic [1:0]  req_kind = 0;
  logic [23:0] req_addr = 0;
  logic memr_n, memw_n, smemr_n, smemw_n, ior_n, iow_n, bhe_n, refo_n;
  logic ale, aen, cmd_oe, ref_oe, hreq, raddr_oe, done;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  isa_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_bhe_i(req_bhe), .req_dma_i(req_dma), .ref_req_i(ref_req),
    .master_ni(master_n), .ref_ni(ref_n), .mcs16_ni(mcs16_n), .zws_ni(zws_n),
    .iochrdy_i(rdy), .host_gnt_i(gnt), .memr_no(memr_n), .memw_no(memw_n),
    .smemr_no(smemr_n), .smemw_no(smemw_n), .ior_no(ior_n), .iow_no(iow_n),
    .bhe_no(bhe_n), .ref_no(refo_n), .ale_o(ale), .aen_o(aen), .cmd_oe_o(cmd_oe),
    .ref_oe_o(ref_oe), .host_req_o(hreq), .raddr_oe_o(raddr_oe), .done_o(done)
  );

  // {kind, addr, bhe, mcs16_n, dma, zws_at, rdy_low_until, len, strobes}
  function automatic logic [48:0] mk(input logic [1:0] k, input logic [23:0] a,
      input logic b, m, d, input logic [3:0] z, r, input logic [4:0] l, input logic [6:0] e);
    return {k, a, b, m, d, z, r, l, e};
  endfunction

  localparam int NV = 10;
  localparam logic [48:0] VEC [NV] = '{
    mk(2'd0, 24'h0F1234, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 5'd6, 7'b0101111),
    mk(2'd0, 24'h123456, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 5'd4, 7'b0111110),
    mk(2'd1, 24'h000400, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 5'd4, 7'b1010110),
    mk(2'd1, 24'hF00000, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 5'd6, 7'b1011111),
    mk(2'd2, 24'h0003F8, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 5'd6, 7'b1111011),
    mk(2'd3, 24'h000080, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0, 5'd6, 7'b1111101),
    mk(2'd0, 24'h000010, 1'b1, 1'b0, 1'b0, 4'd0, 4'd6, 5'd7, 7'b0101110),
    mk(2'd2, 24'h000300, 1'b0, 1'b1, 1'b0, 4'd2, 4'd0, 5'd2, 7'b1111011),
    mk(2'd1, 24'h800000, 1'b0, 1'b1, 1'b0, 4'd0, 4'd8, 5'd9, 7'b1011111),
    mk(2'd0, 24'h0A0000, 1'b0, 1'b0, 1'b0, 4'd1, 4'd3, 5'd1, 7'b0101111)
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] strobes();
    return {memr_n, memw_n, smemr_n, smemw_n, ior_n, iow_n, bhe_n};
  endfunction

  task automatic run_vec(input logic [48:0] v, input int ref_pulses);
    int c;
    req_kind = v[48:47]; req_addr = v[46:23]; req_bhe = v[22]; mcs16_n = v[21];
    req_dma = v[20]; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    chk(ale == 1'b1, "R2 ale in address clock", 32'(ale), 1);
    chk(bhe_n == !v[22], "R4 bhe in address clock", 32'(bhe_n), 32'(!v[22]));
    chk(aen == v[20], "R10 aen in address clock", 32'(aen), 32'(v[20]));
    step();
    c = 0;
    while ({memr_n, memw_n, ior_n, iow_n} != 4'hF && c < 20) begin
      c++;
      chk(strobes() == v[6:0], "R3 R4 strobe set", 32'(strobes()), 32'(v[6:0]));
      rdy   = (c > int'(v[15:12]));
      zws_n = !(c == int'(v[19:16]));
      ref_req = (c <= ref_pulses);
      step();
    end
    rdy = 1'b1; zws_n = 1'b1; ref_req = 1'b0;
    chk(c == int'(v[11:7]), "R2 R5 R6 command length", 32'(c), 32'(v[11:7]));
    chk(done == 1'b1, "R2 done after command", 32'(done), 1);
  endtask

  // refresh from the request phase; returns after the done sample
  task automatic run_ref(input bit expect_drive);
    int w, h, c;
    w = 0;
    while (!hreq && w < 6) begin w++; step(); end
    chk(hreq == 1'b1, "R7 host request raised", 32'(hreq), 1);
    chk(ref_oe == expect_drive, "R7 R9 ref output enable", 32'(ref_oe), 32'(expect_drive));
    if (expect_drive) chk(refo_n == 1'b0, "R7 REF low", 32'(refo_n), 0);
    gnt = 1'b0; step(); step();
    chk(hreq == 1'b1 && raddr_oe == 1'b0, "R7 waits for grant", 32'({hreq, raddr_oe}), 2);
    gnt = 1'b1;
    h = 0;
    step();
    while (hreq && h < 10) begin
      if (raddr_oe) h++;
      step();
    end
    gnt = 1'b0;
    chk(h == 2, "R7 host hold clocks", 32'(h), 2);
    mcs16_n = 1'b0;
    c = 0;
    while (!memr_n && c < 20) begin
      c++;
      chk(smemr_n == 1'b0 && hreq == 1'b0, "R7 refresh read strobes", 32'({smemr_n, hreq}), 0);
      step();
    end
    mcs16_n = 1'b1;
    chk(c == 6, "R6 R7 refresh command length", 32'(c), 6);
    chk(done == 1'b1, "R7 refresh done", 32'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    step();
    chk({memr_n, memw_n, smemr_n, smemw_n, ior_n, iow_n, bhe_n, refo_n} == 8'hFF,
        "R1 strobes in reset", 32'({memr_n, memw_n, ior_n, iow_n}), 32'hF);
    chk({ale, aen, hreq, done} == 4'b0, "R1 controls in reset", 32'({ale, aen, hreq, done}), 0);
    step();
    rst_ni = 1'b1;
    step();
    chk({ale, aen, hreq, done, memr_n} == 5'b00001, "R1 idle after reset",
        32'({ale, aen, hreq, done, memr_n}), 1);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], 0);
      step();
      chk(done == 1'b0, "R2 done is one clock", 32'(done), 0);
    end

    // standalone refresh
    ref_req = 1'b1; step(); ref_req = 1'b0;
    run_ref(1'b1);
    step();
    chk(hreq == 1'b0 && done == 1'b0, "R8 back to idle", 32'({hreq, done}), 0);

    // refresh requested twice during a cycle: one refresh, right after done
    run_vec(VEC[0], 2);
    step();
    chk(hreq == 1'b1, "R8 pending refresh follows done", 32'(hreq), 1);
    run_ref(1'b1);
    step();
    chk(hreq == 1'b0, "R8 only one refresh served", 32'(hreq), 0);
    step();
    chk(hreq == 1'b0 && memr_n == 1'b1, "R8 stays idle", 32'({hreq, memr_n}), 1);

    // card owns the bus
    master_n = 1'b0;
    step();
    chk(cmd_oe == 1'b0 && ref_oe == 1'b0, "R9 outputs released", 32'({cmd_oe, ref_oe}), 0);
    req_kind = 2'd0; req_addr = 24'h000100; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    chk(ale == 1'b0, "R9 request ignored", 32'(ale), 0);
    step();
    chk(memr_n == 1'b1 && ale == 1'b0, "R9 no cycle started", 32'({memr_n, ale}), 2);
    ref_n = 1'b0;
    step();
    ref_n = 1'b1;
    run_ref(1'b0);
    step();
    master_n = 1'b1;
    step();
    chk(cmd_oe == 1'b1 && ref_oe == 1'b1, "R9 outputs driven again", 32'({cmd_oe, ref_oe}), 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule